// File: doc/BRIEF.md
# Command Decoder and Bank Rule Checker for a Four-Bank DDR Memory

This block watches the command pins of a four-bank double-data-rate memory device on every rising clock edge. It turns the pin pattern into a command code and keeps a small state machine for each bank. It flags any command that breaks a state rule or a minimum-spacing rule, and it reports why. It is meant to sit beside a memory controller or a device model as a protocol monitor. It does not store data and has no view of the memory array.

Each sampled command produces a registered result one clock later. That result is the decoded code, a legal flag, a one-cycle violation pulse, and a reason code. Bank states are updated on the same edge that samples the command, so `bank_state_o` always shows the state after the most recent edge. Every minimum spacing is a parameter counted in clock cycles. The defaults suit a 6 ns clock: tRCD=3, tRP=3, tRAS=7, tRC=10, tRRD=2, tRFC=12, tMRD=2. An auto-precharge access holds its bank for a further 4 cycles (`T_APB`). Every spacing parameter must be at least 2. The inputs carry no payload, so the block has no valid/ready handshake and its control and status pins are plain.

Top module: `sdc_cmd_checker`

## Requirements
- R1: The command is decoded in two steps. With `cke` high and `cs_n` high, the code is 0 (deselect). With `cke` high and `cs_n` low, the pins {ras_n,cas_n,we_n} select the command:
  - 111 gives NOP = 1.
  - 110 gives burst stop = 2.
  - 101 gives read = 3.
  - 100 gives write = 4.
  - 011 gives activate = 5.
  - 010 gives precharge = 6.
  - 001 gives refresh = 8.
  - 000 gives mode write = 9.
- R2: A deselect (code 0) is always legal and changes nothing. Bank timers already running keep running, so an activating bank still becomes open on time.
- R3: Address bit 10 and bank-select bit 0 refine the decode:
  - With bit 10 high, read becomes 14 and write becomes 15 (auto-precharge).
  - With bit 10 high, precharge becomes 7 (all banks).
  - A mode write with `ba[0]`=1 becomes 10 (extended register).
- R4: When `cke` is low and was high on the previous edge, the code is 12 (self-refresh entry) if the pins show the refresh pattern, and 11 (power-down entry) otherwise. When `cke` is low on two edges in a row, the code is 13 and is always legal.
- R5: A read or write to an idle or precharging bank is illegal with reason 1. A read or write to a bank still inside tRCD after activate is illegal with reason 5.
- R6: An activate is checked against the addressed bank and the device:
  - To an open or activating bank, it fails with reason 2.
  - To a precharging bank, it fails with reason 6.
  - Within tRC of that bank's previous activate, it fails with reason 8.
  - Within tRRD of any activate, it fails with reason 9.
- R7: Refresh, mode writes, power-down entry and self-refresh entry are illegal with reason 3 unless every bank is idle.
- R8: A legal auto-precharge access puts its bank in state 4 for `T_APB` cycles, then in state 3 for tRP cycles, then in idle. Any read, write, activate or precharge that reaches that bank while it is in state 4 fails with reason 4.
- R9: A precharge to an open bank before tRAS has elapsed, or to an activating bank, fails with reason 7. A precharge to an idle or precharging bank is legal and does nothing. An all-bank precharge reports the reason of the lowest-numbered offending bank.
- R10: Within tRFC after a legal refresh, any command other than deselect, NOP and code 13 fails with reason 10. Within tMRD after a legal mode write, such a command fails with reason 11.
- R11: Outputs are registered one cycle after the sampling edge. An illegal command sets `legal_o` low, pulses `viol_o` and gives a nonzero `reason_o`, and it changes no bank state or timer. When two rules are broken at once, the reason is chosen in this order: tRFC, then tMRD, then reason 3, then the bank rule, then tRRD. Reset gives code 0, legal 1, no violation, reason 0 and all banks idle, and it treats `cke` as previously low.
- R12: Bank `b` reports its state in `bank_state_o[3b+2:3b]`, using idle=0, activating=1, open=2, precharging=3 and auto-precharge=4. After an activate the bank is activating for tRCD edges and then open. After a precharge it is precharging for tRP edges and then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock-enable pin level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Address pins; only bit 10 is decoded |
| cmd_o | output | 4 | Decoded command code (R1, R3, R4) |
| legal_o | output | 1 | High when the last sampled command was legal |
| viol_o | output | 1 | One-cycle pulse for an illegal command |
| reason_o | output | 4 | Violation reason, 0 when the command was legal |
| bank_state_o | output | 12 | Packed 3-bit state of each bank |

## Verification
The bench aims at the edges of each spacing window. It probes the last cycle that must still be refused and the first cycle that must be accepted. A counter that is off by one would refuse the first legal activate or accept one cycle early. The auto-precharge path is followed through each of its states until the bank is idle again: a read to a locked bank, and an activate to a bank still precharging or still inside tRC. A design that returned the bank to idle too early, or that let an illegal command alter bank state, would show the wrong state vector. Further cases cover an all-bank precharge where two banks break rules at once, and an activate blocked by tRRD on a different bank. Two more cover self-refresh entry with banks open and a deselect during activation; a design that froze its timers on deselect would leave that bank activating.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_BST   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_PREA  = 4'd7,
    CMD_REF   = 4'd8,
    CMD_MRS   = 4'd9,
    CMD_EMRS  = 4'd10,
    CMD_PDE   = 4'd11,
    CMD_SRE   = 4'd12,
    CMD_LPW   = 4'd13,
    CMD_RDA   = 4'd14,
    CMD_WRA   = 4'd15
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE = 3'd0,
    BK_ACTV = 3'd1,
    BK_OPEN = 3'd2,
    BK_PCHG = 3'd3,
    BK_APRE = 3'd4
  } bank_e;

  typedef enum logic [3:0] {
    RS_NONE     = 4'd0,
    RS_IDLE_ACC = 4'd1,
    RS_ROW_OPEN = 4'd2,
    RS_NOT_IDLE = 4'd3,
    RS_AP_LOCK  = 4'd4,
    RS_TRCD     = 4'd5,
    RS_TRP      = 4'd6,
    RS_TRAS     = 4'd7,
    RS_TRC      = 4'd8,
    RS_TRRD     = 4'd9,
    RS_TRFC     = 4'd10,
    RS_TMRD     = 4'd11
  } rsn_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
  import sdc_pkg::*;
(
  input  logic cke,
  input  logic cke_q,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ba0,
  input  logic a10,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cke) begin
      // R4: falling edge of cke selects an entry, held low is a sleep cycle
      if (!cke_q)
        cmd = CMD_LPW;
      else if (!cs_n && !ras_n && !cas_n && we_n)
        cmd = CMD_SRE;
      else
        cmd = CMD_PDE;
    end else if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111: cmd = CMD_NOP;
        3'b110: cmd = CMD_BST;
        3'b101: cmd = a10 ? CMD_RDA : CMD_RD;
        3'b100: cmd = a10 ? CMD_WRA : CMD_WR;
        3'b011: cmd = CMD_ACT;
        3'b010: cmd = a10 ? CMD_PREA : CMD_PRE;
        3'b001: cmd = CMD_REF;
        default: cmd = ba0 ? CMD_EMRS : CMD_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdc_gap.sv
module sdc_gap #(
  parameter int CW  = 4,
  parameter int GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= CW'(GAP - 1);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank
  import sdc_pkg::*;
#(
  parameter int CW    = 4,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 7,
  parameter int T_RC  = 10,
  parameter int T_APB = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  cmd_e  cmd,
  input  logic  hit,
  input  logic  commit,
  output bank_e state,
  output rsn_e  rsn,
  output logic  idle
);
  logic [CW-1:0] tcnt, ras_cnt, rc_cnt;

  assign idle = (state == BK_IDLE);

  always_comb begin
    rsn = RS_NONE;
    case (cmd)
      CMD_RD, CMD_WR, CMD_RDA, CMD_WRA: begin
        if (hit) begin
          case (state)
            BK_IDLE, BK_PCHG: rsn = RS_IDLE_ACC;
            BK_ACTV:          rsn = RS_TRCD;
            BK_APRE:          rsn = RS_AP_LOCK;
            default:          rsn = RS_NONE;
          endcase
        end
      end
      CMD_ACT: begin
        if (hit) begin
          case (state)
            BK_APRE:          rsn = RS_AP_LOCK;
            BK_ACTV, BK_OPEN: rsn = RS_ROW_OPEN;
            BK_PCHG:          rsn = RS_TRP;
            default:          rsn = (rc_cnt != '0) ? RS_TRC : RS_NONE;
          endcase
        end
      end
      CMD_PRE, CMD_PREA: begin
        if (hit || cmd == CMD_PREA) begin
          case (state)
            BK_APRE: rsn = RS_AP_LOCK;
            BK_ACTV: rsn = RS_TRAS;
            BK_OPEN: rsn = (ras_cnt != '0) ? RS_TRAS : RS_NONE;
            default: rsn = RS_NONE;
          endcase
        end
      end
      default: rsn = RS_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= BK_IDLE;
      tcnt    <= '0;
      ras_cnt <= '0;
      rc_cnt  <= '0;
    end else begin
      if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
      if (rc_cnt != '0)  rc_cnt  <= rc_cnt - 1'b1;
      if (tcnt != '0)    tcnt    <= tcnt - 1'b1;
      if (tcnt == CW'(1)) begin
        case (state)
          BK_ACTV: state <= BK_OPEN;
          BK_APRE: begin
            state <= BK_PCHG;
            tcnt  <= CW'(T_RP - 1);
          end
          BK_PCHG: state <= BK_IDLE;
          default: ;
        endcase
      end
      if (commit && hit && cmd == CMD_ACT) begin
        state   <= BK_ACTV;
        tcnt    <= CW'(T_RCD - 1);
        ras_cnt <= CW'(T_RAS - 1);
        rc_cnt  <= CW'(T_RC - 1);
      end
      if (commit && hit && (cmd == CMD_RDA || cmd == CMD_WRA)) begin
        state <= BK_APRE;
        tcnt  <= CW'(T_APB - 1);
      end
      if (commit && state == BK_OPEN &&
          ((hit && cmd == CMD_PRE) || cmd == CMD_PREA)) begin
        state <= BK_PCHG;
        tcnt  <= CW'(T_RP - 1);
      end
    end
  end
endmodule

// File: rtl/sdc_cmd_checker.sv
module sdc_cmd_checker
  import sdc_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BAW   = 2,
  parameter int AW    = 13,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 7,
  parameter int T_RC  = 10,
  parameter int T_RRD = 2,
  parameter int T_RFC = 12,
  parameter int T_MRD = 2,
  parameter int T_APB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BAW-1:0]       ba,
  input  logic [AW-1:0]        addr,
  output logic [3:0]           cmd_o,
  output logic                 legal_o,
  output logic                 viol_o,
  output logic [3:0]           reason_o,
  output logic [3*NBANK-1:0]   bank_state_o
);
  localparam int A10  = 10;
  localparam int TMAX = imax(imax(imax(T_RCD, T_RP), imax(T_RAS, T_RC)),
                             imax(imax(T_RRD, T_RFC), imax(T_MRD, T_APB)));
  localparam int CW   = $clog2(TMAX + 1);

  logic cke_q;
  cmd_e cmd;
  rsn_e rsn, bank_rsn;
  logic commit, all_idle, rrd_busy, rfc_busy, mrd_busy;
  rsn_e brsn [NBANK];
  logic [NBANK-1:0] idle_v;
  logic unused_addr;

  assign unused_addr = ^{addr[AW-1:A10+1], addr[A10-1:0]};

  sdc_decode u_dec (
    .cke(cke), .cke_q(cke_q), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba0(ba[0]), .a10(addr[A10]), .cmd(cmd)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_e st;
    sdc_bank #(.CW(CW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
               .T_RC(T_RC), .T_APB(T_APB)) u_bank (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .hit(ba == BAW'(b)),
      .commit(commit), .state(st), .rsn(brsn[b]), .idle(idle_v[b])
    );
    assign bank_state_o[3*b +: 3] = st;
  end

  sdc_gap #(.CW(CW), .GAP(T_RRD)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(commit && cmd == CMD_ACT), .busy(rrd_busy));
  sdc_gap #(.CW(CW), .GAP(T_RFC)) u_rfc (
    .clk(clk), .rst_n(rst_n), .load(commit && cmd == CMD_REF), .busy(rfc_busy));
  sdc_gap #(.CW(CW), .GAP(T_MRD)) u_mrd (
    .clk(clk), .rst_n(rst_n),
    .load(commit && (cmd == CMD_MRS || cmd == CMD_EMRS)), .busy(mrd_busy));

  assign all_idle = &idle_v;

  // lowest-numbered offending bank wins (matters for all-bank precharge)
  always_comb begin
    bank_rsn = RS_NONE;
    for (int b = NBANK - 1; b >= 0; b--)
      if (brsn[b] != RS_NONE) bank_rsn = brsn[b];
  end

  always_comb begin
    logic quiet, need_idle;
    quiet     = (cmd inside {CMD_DESEL, CMD_NOP, CMD_LPW});
    need_idle = (cmd inside {CMD_REF, CMD_MRS, CMD_EMRS, CMD_PDE, CMD_SRE});
    if (!quiet && rfc_busy)               rsn = RS_TRFC;
    else if (!quiet && mrd_busy)          rsn = RS_TMRD;
    else if (need_idle && !all_idle)      rsn = RS_NOT_IDLE;
    else if (bank_rsn != RS_NONE)         rsn = bank_rsn;
    else if (cmd == CMD_ACT && rrd_busy)  rsn = RS_TRRD;
    else                                  rsn = RS_NONE;
  end

  assign commit = (rsn == RS_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q    <= 1'b0;
      cmd_o    <= CMD_DESEL;
      legal_o  <= 1'b1;
      viol_o   <= 1'b0;
      reason_o <= RS_NONE;
    end else begin
      cke_q    <= cke;
      cmd_o    <= cmd;
      legal_o  <= commit;
      viol_o   <= !commit;
      reason_o <= rsn;
    end
  end
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
  import sdc_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int T_RFC = 12,
  parameter int T_MRD = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         cmd_o,
  input logic               legal_o,
  input logic               viol_o,
  input logic [3:0]         reason_o,
  input logic [3*NBANK-1:0] bank_state_o
);
  localparam logic [3:0] C_DESEL = CMD_DESEL;
  localparam logic [3:0] C_NOP   = CMD_NOP;
  localparam logic [3:0] C_LPW   = CMD_LPW;
  localparam logic [3:0] C_REF   = CMD_REF;
  localparam logic [3:0] C_MRS   = CMD_MRS;
  localparam logic [3:0] C_EMRS  = CMD_EMRS;

  assert_viol_reason_R11: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (reason_o != 4'd0 && !legal_o));

  assert_desel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == C_DESEL) |-> legal_o);

  assert_sleep_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == C_LPW) |-> legal_o);

  assert_ref_all_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_o && cmd_o == C_REF) |-> (bank_state_o == '0));

  assert_rfc_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RFC > 1 && legal_o && cmd_o == C_REF) |=>
      (!legal_o || cmd_o == C_DESEL || cmd_o == C_NOP || cmd_o == C_LPW));

  assert_mrd_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (T_MRD > 1 && legal_o && (cmd_o == C_MRS || cmd_o == C_EMRS)) |=>
      (!legal_o || cmd_o == C_DESEL || cmd_o == C_NOP || cmd_o == C_LPW));

  for (genvar b = 0; b < NBANK; b++) begin : g_enc
    assert_state_enc_R12: assert property (@(posedge clk) disable iff (!rst_n)
      bank_state_o[3*b +: 3] <= 3'd4);
  end
endmodule

bind sdc_cmd_checker sdc_checker #(.NBANK(NBANK), .T_RFC(T_RFC), .T_MRD(T_MRD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_o(cmd_o), .legal_o(legal_o), .viol_o(viol_o),
  .reason_o(reason_o), .bank_state_o(bank_state_o)
);

// File: tb/tb_sdc_cmd_checker.sv
module tb_sdc_cmd_checker;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic [3:0] cmd_o, reason_o;
  logic legal_o, viol_o;
  logic [11:0] bank_state_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  sdc_cmd_checker dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
    .legal_o(legal_o), .viol_o(viol_o), .reason_o(reason_o),
    .bank_state_o(bank_state_o)
  );

  typedef struct packed {
    logic [3:0] c;
    logic [1:0] b;
    logic [3:0] r;
    logic [2:0] s1;
    logic [2:0] s0;
  } vec_t;

  // main walk: code, bank, expected reason, expected bank1/bank0 state
  localparam vec_t TBL [26] = '{
    '{4'd1,  2'd0, 4'd0, 3'd0, 3'd0},
    '{4'd5,  2'd0, 4'd0, 3'd0, 3'd1},
    '{4'd5,  2'd1, 4'd9, 3'd0, 3'd1},
    '{4'd3,  2'd0, 4'd5, 3'd0, 3'd2},
    '{4'd5,  2'd1, 4'd0, 3'd1, 3'd2},
    '{4'd3,  2'd0, 4'd0, 3'd1, 3'd2},
    '{4'd5,  2'd0, 4'd2, 3'd2, 3'd2},
    '{4'd6,  2'd0, 4'd7, 3'd2, 3'd2},
    '{4'd6,  2'd0, 4'd0, 3'd2, 3'd3},
    '{4'd5,  2'd0, 4'd6, 3'd2, 3'd3},
    '{4'd4,  2'd0, 4'd1, 3'd2, 3'd0},
    '{4'd4,  2'd0, 4'd1, 3'd2, 3'd0},
    '{4'd15, 2'd1, 4'd0, 3'd4, 3'd0},
    '{4'd3,  2'd1, 4'd4, 3'd4, 3'd0},
    '{4'd7,  2'd0, 4'd4, 3'd4, 3'd0},
    '{4'd1,  2'd0, 4'd0, 3'd3, 3'd0},
    '{4'd5,  2'd0, 4'd0, 3'd3, 3'd1},
    '{4'd8,  2'd0, 4'd3, 3'd0, 3'd1},
    '{4'd5,  2'd1, 4'd0, 3'd1, 3'd2},
    '{4'd7,  2'd0, 4'd7, 3'd1, 3'd2},
    '{4'd9,  2'd0, 4'd3, 3'd2, 3'd2},
    '{4'd2,  2'd0, 4'd0, 3'd2, 3'd2},
    '{4'd0,  2'd0, 4'd0, 3'd2, 3'd2},
    '{4'd12, 2'd0, 4'd3, 3'd2, 3'd2},
    '{4'd13, 2'd0, 4'd0, 3'd2, 3'd2},
    '{4'd1,  2'd0, 4'd0, 3'd2, 3'd2}
  };

  function automatic string rtag(input logic [3:0] r);
    case (r)
      4'd1, 4'd5:             return "R5";
      4'd2, 4'd6, 4'd8, 4'd9: return "R6";
      4'd3:                   return "R7";
      4'd4:                   return "R8";
      4'd7:                   return "R9";
      4'd10, 4'd11:           return "R10";
      default:                return "R11";
    endcase
  endfunction

  function automatic logic [11:0] bsv(input logic [2:0] s3, input logic [2:0] s2,
                                      input logic [2:0] s1, input logic [2:0] s0);
    return {s3, s2, s1, s0};
  endfunction

  // pin patterns per R1, R3, R4
  task automatic put(input logic [3:0] c, input logic [1:0] b);
    logic [2:0] p;
    cke = 1'b1; cs_n = 1'b0; addr = '0; ba = b; p = 3'b111;
    case (c)
      4'd0:  cs_n = 1'b1;
      4'd1:  p = 3'b111;
      4'd2:  p = 3'b110;
      4'd3:  p = 3'b101;
      4'd14: begin p = 3'b101; addr[10] = 1'b1; end
      4'd4:  p = 3'b100;
      4'd15: begin p = 3'b100; addr[10] = 1'b1; end
      4'd5:  p = 3'b011;
      4'd6:  p = 3'b010;
      4'd7:  begin p = 3'b010; addr[10] = 1'b1; end
      4'd8:  p = 3'b001;
      4'd9:  begin p = 3'b000; ba = 2'd0; end
      4'd10: begin p = 3'b000; ba = 2'd1; end
      4'd11: begin cke = 1'b0; p = 3'b111; end
      4'd12: begin cke = 1'b0; p = 3'b001; end
      default: begin cke = 1'b0; cs_n = 1'b1; end
    endcase
    {ras_n, cas_n, we_n} = p;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] c, input logic [1:0] b, input logic [3:0] r,
                      input logic [11:0] bs, input string tag);
    put(c, b);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "cmd", cmd_o, c);
    chk(tag, "reason", reason_o, r);
    chk(tag, "viol/legal", {viol_o, legal_o}, (r != 0) ? 2 : 1);
    chk("R12", "bank states", bank_state_o, bs);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cke = 1'b0; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset values
    chk("R11", "reset cmd", cmd_o, 0);
    chk("R11", "reset legal/viol", {legal_o, viol_o}, 2);
    chk("R11", "reset reason", reason_o, 0);
    chk("R11", "reset banks", bank_state_o, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // table walk: decode (R1, R3, R4), bank rules, spacing, priority
    foreach (TBL[i]) begin
      step(TBL[i].c, TBL[i].b, TBL[i].r,
           bsv(3'd0, 3'd0, TBL[i].s1, TBL[i].s0), rtag(TBL[i].r));
    end

    // R2: deselect keeps the activation timer running
    do_reset();
    step(4'd1, 2'd0, 4'd0, 12'd0, "R2");
    step(4'd5, 2'd2, 4'd0, bsv(0, 1, 0, 0), "R2");
    step(4'd0, 2'd0, 4'd0, bsv(0, 1, 0, 0), "R2");
    step(4'd0, 2'd0, 4'd0, bsv(0, 2, 0, 0), "R2");

    // R8 / R6: auto-precharge life cycle, then tRP and tRC edges
    do_reset();
    step(4'd1, 2'd0, 4'd0, 12'd0, "R8");
    step(4'd5, 2'd3, 4'd0, bsv(1, 0, 0, 0), "R8");
    step(4'd1, 2'd0, 4'd0, bsv(1, 0, 0, 0), "R8");
    step(4'd1, 2'd0, 4'd0, bsv(2, 0, 0, 0), "R8");
    step(4'd14, 2'd3, 4'd0, bsv(4, 0, 0, 0), "R8");
    step(4'd1, 2'd0, 4'd0, bsv(4, 0, 0, 0), "R8");
    step(4'd1, 2'd0, 4'd0, bsv(4, 0, 0, 0), "R8");
    step(4'd1, 2'd0, 4'd0, bsv(3, 0, 0, 0), "R8");
    step(4'd1, 2'd0, 4'd0, bsv(3, 0, 0, 0), "R8");
    step(4'd5, 2'd3, 4'd6, bsv(0, 0, 0, 0), "R6");
    step(4'd5, 2'd3, 4'd8, bsv(0, 0, 0, 0), "R6");  // R11: no state change
    step(4'd5, 2'd3, 4'd0, bsv(1, 0, 0, 0), "R6");

    // R10: refresh spacing, last refused and first accepted cycle
    do_reset();
    step(4'd1, 2'd0, 4'd0, 12'd0, "R10");
    step(4'd8, 2'd0, 4'd0, 12'd0, "R10");
    for (int k = 0; k < 10; k++) step(4'd1, 2'd0, 4'd0, 12'd0, "R10");
    step(4'd5, 2'd0, 4'd10, 12'd0, "R10");
    step(4'd5, 2'd0, 4'd0, bsv(0, 0, 0, 1), "R10");

    // R3 / R10: extended and main mode writes, tMRD edges
    do_reset();
    step(4'd1, 2'd0, 4'd0, 12'd0, "R3");
    step(4'd10, 2'd1, 4'd0, 12'd0, "R3");
    step(4'd1, 2'd0, 4'd0, 12'd0, "R3");
    step(4'd9, 2'd0, 4'd0, 12'd0, "R3");
    step(4'd5, 2'd0, 4'd11, 12'd0, "R10");
    step(4'd5, 2'd0, 4'd0, bsv(0, 0, 0, 1), "R10");

    // R4: power-down entry with all banks idle, sleep, wake
    do_reset();
    step(4'd1, 2'd0, 4'd0, 12'd0, "R4");
    step(4'd11, 2'd0, 4'd0, 12'd0, "R4");
    step(4'd13, 2'd0, 4'd0, 12'd0, "R4");
    step(4'd1, 2'd0, 4'd0, 12'd0, "R4");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule